// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller half of a circular command queue. Software fills a ring in memory with 32-bit command words, one word per slot, then stores the index of the newest valid slot in a write-index register. While the enable bit is set, the engine walks the ring one slot at a time. It steps its consume index forward by one, wrapping at the ring size, and reads that slot through a synchronous memory read port. It then offers the word on a valid/ready command output toward the codec link. The consume index always names the slot taken last, so fetching stops once it matches the write index. One slot therefore always stays empty: software treats the ring as full when (consume index − write index − 1) mod size is zero.

The ring holds 2, 16 or 256 slots. The size is chosen by a 2-bit code, and a read-only capability field shows which codes the hardware accepts. The consume index is not loaded directly. Software clears it with a two-step handshake: write the clear bit as 1, which forces the index to zero and keeps it there, then write the bit as 0 to let fetching resume. Four word-wide registers sit on a simple write-strobe bus whose read data is combinational.

The fetch controller has three states. IDLE moves to WAIT and issues the memory read when the enable bit is 1, the clear bit is 0 and the two indices differ (transition "issue"). WAIT always moves to SEND, capturing the returned word (transition "load"). SEND stays in SEND while the output is not taken (transition "stall"). SEND returns to IDLE when the word is accepted (transition "retire"), and the consume index takes the fetched slot number at that moment.

Top module: `cmdring_engine`

## Requirements
- R1: After reset the enable bit is 0, the size code is 0 (2 slots), the consume index and the clear bit are 0, the write index is 0, and no memory read or command output is active.
- R2: Register address 1 reads the capability mask in bits 6:4 and the size code in bits 1:0. A size write takes effect only while the enable bit (address 0, bit 0) is 0 and the code is one the capability allows. Code 3 is never accepted.
- R3: With enable set and the indices different, the engine reads slot (consume index + 1) mod size and delivers the words in ring order until the consume index equals the write index (address 2, bits 7:0).
- R4: Slot numbering wraps from size−1 to 0 for each of the 2-, 16- and 256-slot sizes.
- R5: A presented word keeps cmd_valid high and cmd_data unchanged until cmd_ready. The consume index reads back the new slot number from the cycle after acceptance, and not before.
- R6: While enable is 0, no memory read is started and no new word is presented. A word already fetched when enable is cleared is still delivered and retired.
- R7: Writing address 2 with bit 15 set forces the consume index to 0, and bit 15 reads back 1. While the bit is 1, no fetch is issued. Writing bit 15 as 0 clears it, and fetching resumes at slot 1.
- R8: When a clear write lands in the same cycle as a word acceptance, the clear wins and the consume index reads 0.
- R9: The write index (address 3, bits 7:0) stores the written value masked to the current ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 size, 2 consume index, 3 write index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd_en | output | 1 | Ring memory read request |
| mem_addr | output | 8 | Ring slot to read |
| mem_rdata | input | 32 | Ring word, valid one cycle after the request |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Command word taken |
| cmd_data | output | 32 | Command word |

## Verification
Two of the engine's functions can land in the same cycle: retiring an accepted word, which advances the consume index, and a software clear of that index. To provoke this, the bench holds cmd_ready low until a word is waiting, then in a single cycle raises cmd_ready and writes the clear bit. The word must still reach the scoreboard, and the consume index must then read back as 0 with the clear bit set, never as the retired slot number. A second overlap, clearing the enable bit while a word is waiting, is judged by the word still arriving and the index still advancing. After that, no further memory read may occur.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int IDX_W = 8;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SIZE = 2'd1;
    localparam logic [1:0] REG_RPTR = 2'd2;
    localparam logic [1:0] REG_WPTR = 2'd3;

    localparam int RUN_BIT = 0;
    localparam int CLR_BIT = 15;
    localparam int CAP_LSB = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } fetch_state_t;

    function automatic logic [IDX_W-1:0] size_mask(input logic [1:0] code);
        logic [IDX_W-1:0] m;
        unique case (code)
            2'd0:    m = IDX_W'(1);
            2'd1:    m = IDX_W'(15);
            2'd2:    m = IDX_W'(255);
            default: m = IDX_W'(1);
        endcase
        return m;
    endfunction

    function automatic logic code_allowed(input logic [2:0] cap, input logic [1:0] code);
        logic ok;
        unique case (code)
            2'd0:    ok = cap[0];
            2'd1:    ok = cap[1];
            2'd2:    ok = cap[2];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter logic [2:0] CAP_MASK = 3'b111,
    parameter int         DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [IDX_W-1:0]  rp,
    output logic              run,
    output logic [1:0]        size_sel,
    output logic              hold,
    output logic              rp_clr,
    output logic [IDX_W-1:0]  wp,
    output logic [IDX_W-1:0]  mask,
    output logic [DATA_W-1:0] reg_rdata
);

    logic run_q;
    logic hold_q;
    logic [1:0] sel_q;
    logic [IDX_W-1:0] wp_q;

    logic wr_ctrl, wr_size, wr_rptr, wr_wptr;
    logic size_take;
    logic wdata_unused;

    assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
    assign wr_size = reg_we && (reg_addr == REG_SIZE);
    assign wr_rptr = reg_we && (reg_addr == REG_RPTR);
    assign wr_wptr = reg_we && (reg_addr == REG_WPTR);

    assign size_take    = wr_size && !run_q && code_allowed(CAP_MASK, reg_wdata[1:0]);
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
            sel_q  <= 2'd0;
            wp_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= reg_wdata[RUN_BIT];
            end
            if (size_take) begin
                sel_q <= reg_wdata[1:0];
            end
            if (wr_rptr) begin
                hold_q <= reg_wdata[CLR_BIT];
            end
            if (wr_wptr) begin
                wp_q <= reg_wdata[IDX_W-1:0] & size_mask(sel_q);
            end
        end
    end

    assign run      = run_q;
    assign hold     = hold_q;
    assign size_sel = sel_q;
    assign wp       = wp_q;
    assign mask     = size_mask(sel_q);
    assign rp_clr   = hold_q || (wr_rptr && reg_wdata[CLR_BIT]);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: reg_rdata[RUN_BIT] = run_q;
            REG_SIZE: begin
                reg_rdata[1:0]             = sel_q;
                reg_rdata[CAP_LSB+2:CAP_LSB] = CAP_MASK;
            end
            REG_RPTR: begin
                reg_rdata[IDX_W-1:0] = rp;
                reg_rdata[CLR_BIT]   = hold_q;
            end
            REG_WPTR: reg_rdata[IDX_W-1:0] = wp_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdring_rptr.sv
module cmdring_rptr
    import cmdring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv_en,
    input  logic [IDX_W-1:0] adv_idx,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] rp,
    output logic [IDX_W-1:0] nxt_idx
);

    logic [IDX_W-1:0] rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else if (clr) begin
            rp_q <= '0;
        end else if (adv_en) begin
            rp_q <= adv_idx;
        end
    end

    assign rp      = rp_q;
    assign nxt_idx = (rp_q + IDX_W'(1)) & mask;

endmodule

// File: rtl/cmdring_fsm.sv
module cmdring_fsm
    import cmdring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hold,
    input  logic              pending,
    input  logic [IDX_W-1:0]  nxt_idx,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cmd_ready,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_addr,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    output logic              adv_en,
    output logic [IDX_W-1:0]  adv_idx
);

    fetch_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic start;

    assign start = run && !hold && pending;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WAIT;
            ST_WAIT: state_d = ST_SEND;
            ST_SEND: if (cmd_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                idx_q <= nxt_idx;
            end
            if (state_q == ST_WAIT) begin
                data_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_rd_en = 1'b0;
        cmd_valid = 1'b0;
        adv_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: mem_rd_en = start;
            ST_WAIT: ;
            ST_SEND: begin
                cmd_valid = 1'b1;
                adv_en    = cmd_ready;
            end
            default: ;
        endcase
    end

    assign mem_addr = nxt_idx;
    assign cmd_data = data_q;
    assign adv_idx  = idx_q;

endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
    import cmdring_pkg::*;
#(
    parameter logic [2:0] CAP_MASK = 3'b111,
    parameter int         DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] cmd_data
);

    logic run, hold, rp_clr;
    logic [1:0] size_sel;
    logic [IDX_W-1:0] wp, rp, mask, nxt_idx, adv_idx;
    logic adv_en;
    logic pending;

    assign pending = (rp != wp);

    cmdring_regs #(.CAP_MASK(CAP_MASK), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rp        (rp),
        .run       (run),
        .size_sel  (size_sel),
        .hold      (hold),
        .rp_clr    (rp_clr),
        .wp        (wp),
        .mask      (mask),
        .reg_rdata (reg_rdata)
    );

    cmdring_rptr u_rptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rp_clr),
        .adv_en  (adv_en),
        .adv_idx (adv_idx),
        .mask    (mask),
        .rp      (rp),
        .nxt_idx (nxt_idx)
    );

    cmdring_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold      (hold),
        .pending   (pending),
        .nxt_idx   (nxt_idx),
        .mem_rdata (mem_rdata),
        .cmd_ready (cmd_ready),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .adv_en    (adv_en),
        .adv_idx   (adv_idx)
    );

endmodule

// File: rtl/cmdring_engine_chk.sv
module cmdring_engine_chk
    import cmdring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              hold,
    input logic              rp_clr,
    input logic [1:0]        size_sel,
    input logic [IDX_W-1:0]  rp,
    input logic              mem_rd_en,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] cmd_data
);

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    p_index_moves_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && cmd_ready) && !rp_clr) |=> $stable(rp));

    p_no_fetch_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (run && !hold));

    p_clear_holds_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (rp == '0));

    p_read_then_offer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 cmd_valid);

    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_size_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(size_sel));

    p_size_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        size_sel != 2'd3);

endmodule

bind cmdring_engine cmdring_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .hold      (hold),
    .rp_clr    (rp_clr),
    .size_sel  (size_sel),
    .rp        (rp),
    .mem_rd_en (mem_rd_en),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data)
);

// File: tb/cmdring_engine_tb.sv
`timescale 1ns/1ps
module cmdring_engine_tb;
    import cmdring_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_data;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int ready_mode = 1;
    logic [7:0] lfsr = 8'h5a;
    logic [31:0] ring [256];
    logic [31:0] exp_q [$];

    cmdring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_data(cmd_data)
    );

    always @(posedge clk) if (mem_rd_en) mem_rdata <= ring[mem_addr];

    always @(posedge clk) begin
        #1 lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    assign cmd_ready = (ready_mode == 1) || ((ready_mode == 2) && lfsr[0]);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: samples just before the next rising edge
    always @(negedge clk) begin
        #1.5;
        if (rst_n) begin
            if (mem_rd_en) rd_cnt++;
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R3 unexpected word actual=%h expected=none", cmd_data);
                end else begin
                    chk("R3 word order", cmd_data, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] word(input int ph, input int idx);
        return 32'hA500_0000 | (ph << 12) | idx;
    endfunction

    task automatic put(input int idx, input logic [31:0] v);
        ring[idx] = v;
        exp_q.push_back(v);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(tag, exp_q.size(), 0);
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!cmd_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic restart(input logic [1:0] code);
        wr(REG_CTRL, 32'h0);
        repeat (4) @(negedge clk);
        wr(REG_SIZE, {30'd0, code});
        wr(REG_RPTR, 32'h8000);
        wr(REG_RPTR, 32'h0);
        wr(REG_WPTR, 32'h0);
    endtask

    initial begin
        #600000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, d0;
        int rc;
        for (int i = 0; i < 256; i++) ring[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(REG_CTRL, v); chk("R1 enable", v, 32'h0);
        rd(REG_SIZE, v); chk("R1 size", v, 32'h70);
        rd(REG_RPTR, v); chk("R1 consume index", v, 32'h0);
        rd(REG_WPTR, v); chk("R1 write index", v, 32'h0);
        chk("R1 no output", {30'd0, cmd_valid, mem_rd_en}, 32'h0);

        // R2 size field
        wr(REG_SIZE, 32'h3); rd(REG_SIZE, v); chk("R2 code 3 ignored", v, 32'h70);
        wr(REG_SIZE, 32'h2); rd(REG_SIZE, v); chk("R2 code 2 taken", v, 32'h72);

        // R3 ordered fetch, random ready
        ready_mode = 2;
        for (int i = 1; i <= 5; i++) put(i, word(1, i));
        wr(REG_WPTR, 32'd5);
        wr(REG_CTRL, 32'h1);
        wr(REG_SIZE, 32'h1);
        drain("R3 drain");
        rd(REG_SIZE, v); chk("R2 size frozen while enabled", v, 32'h72);
        rd(REG_RPTR, v); chk("R3 index at write index", v, 32'd5);

        // R5 stall
        ready_mode = 0;
        put(6, word(2, 6));
        wr(REG_WPTR, 32'd6);
        wait_valid();
        d0 = cmd_data;
        chk("R5 word offered", d0, word(2, 6));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R5 valid held", {31'd0, cmd_valid}, 32'h1);
            chk("R5 data stable", cmd_data, d0);
        end
        rd(REG_RPTR, v); chk("R5 index before accept", v, 32'd5);
        ready_mode = 1;
        rd(REG_RPTR, v); chk("R5 index after accept", v, 32'd6);

        // R6 enable cleared mid-transfer
        ready_mode = 0;
        put(7, word(3, 7));
        wr(REG_WPTR, 32'd7);
        wait_valid();
        wr(REG_CTRL, 32'h0);
        ready_mode = 1;
        repeat (4) @(negedge clk);
        rd(REG_RPTR, v); chk("R6 started word retired", v, 32'd7);
        rc = rd_cnt;
        put(8, word(3, 8));
        wr(REG_WPTR, 32'd8);
        repeat (20) @(negedge clk);
        chk("R6 no read while stopped", rd_cnt, rc);
        chk("R6 no word while stopped", {31'd0, cmd_valid}, 32'h0);
        rd(REG_RPTR, v); chk("R6 index held", v, 32'd7);
        wr(REG_CTRL, 32'h1);
        drain("R6 resume drain");
        rd(REG_RPTR, v); chk("R6 index after resume", v, 32'd8);

        // R9 and R4 with 16 slots
        ready_mode = 2;
        restart(2'd1);
        wr(REG_WPTR, 32'h13); rd(REG_WPTR, v); chk("R9 write index masked", v, 32'd3);
        wr(REG_WPTR, 32'h0);
        for (int i = 1; i <= 15; i++) put(i, word(4, i));
        wr(REG_WPTR, 32'd15);
        wr(REG_CTRL, 32'h1);
        drain("R4 16-slot fill");
        for (int i = 0; i <= 3; i++) put(i, word(5, i));
        wr(REG_WPTR, 32'd3);
        drain("R4 16-slot wrap");
        rd(REG_RPTR, v); chk("R4 16-slot index", v, 32'd3);

        // R4 with 2 slots
        restart(2'd0);
        put(1, word(6, 1));
        wr(REG_WPTR, 32'd1);
        wr(REG_CTRL, 32'h1);
        drain("R4 2-slot first");
        put(0, word(6, 0));
        wr(REG_WPTR, 32'd0);
        drain("R4 2-slot wrap");
        rd(REG_RPTR, v); chk("R4 2-slot index", v, 32'd0);

        // R4 with 256 slots
        restart(2'd2);
        for (int i = 1; i <= 255; i++) put(i, word(7, i));
        wr(REG_WPTR, 32'd255);
        wr(REG_CTRL, 32'h1);
        drain("R4 256-slot fill");
        for (int i = 0; i <= 2; i++) put(i, word(8, i));
        wr(REG_WPTR, 32'd2);
        drain("R4 256-slot wrap");
        rd(REG_RPTR, v); chk("R4 256-slot index", v, 32'd2);

        // R7 clear handshake while enabled
        wr(REG_RPTR, 32'h8000);
        rd(REG_RPTR, v); chk("R7 clear bit set, index zero", v, 32'h8000);
        rc = rd_cnt;
        for (int i = 1; i <= 3; i++) put(i, word(9, i));
        wr(REG_WPTR, 32'd3);
        repeat (10) @(negedge clk);
        chk("R7 no read while clearing", rd_cnt, rc);
        chk("R7 no word while clearing", {31'd0, cmd_valid}, 32'h0);
        wr(REG_RPTR, 32'h0);
        drain("R7 resume from slot 1");
        rd(REG_RPTR, v); chk("R7 index after resume", v, 32'd3);

        // R8 clear and accept in the same cycle
        ready_mode = 0;
        put(4, word(10, 4));
        wr(REG_WPTR, 32'd4);
        wait_valid();
        reg_we = 1'b1; reg_addr = REG_RPTR; reg_wdata = 32'h8000;
        ready_mode = 1;
        @(negedge clk);
        reg_we = 1'b0;
        wr(REG_CTRL, 32'h0);
        wr(REG_WPTR, 32'h0);
        rd(REG_RPTR, v); chk("R8 clear wins over accept", v, 32'h8000);
        chk("R8 word delivered", exp_q.size(), 0);
        wr(REG_RPTR, 32'h0);
        repeat (10) @(negedge clk);
        chk("R8 idle after release", {31'd0, cmd_valid}, 32'h0);
        rd(REG_RPTR, v); chk("R8 index zero", v, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule